// File: doc/BRIEF.md
# LIN Transmit Dominant Timeout Guard

This block sits between the transmit data line coming from the microcontroller and the enable of the LIN bus low-side driver. A low level on the transmit line pulls the bus dominant. A high level leaves the bus recessive, and so does a line that is left floating. The guard makes sure that a stuck-low transmit line cannot hold the bus dominant forever. It counts how long the driver has been pulled dominant. Once that run is too long, it forces the driver recessive and raises a status flag. The driver stays blocked until the transmit line has been high for a qualified minimum time.

The same qualified-high rule applies every time the transceiver enters normal mode. A transmit line that is already low at that moment therefore cannot start driving the bus. Outside normal mode the driver is always off. The transmit input is resynchronized into the clock domain before any counting. An unknown or undriven input is read as high. Both time limits are given as clock-cycle counts, and the counters saturate at their limits instead of wrapping.

Top module: `dom_timeout_guard`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `driveDominant` and `timeoutFlag` are both 0.
- R2: When `normalMode` is 0, `driveDominant` and `timeoutFlag` are 0 from the next clock edge on. This holds whatever `txdIn` does, and the flag also clears if it was set.
- R3: In the driving state, a change of `txdIn` reaches `driveDominant` after `SYNC_STAGES` clock edges. Here `txdIn` = 0 means dominant (`driveDominant` = 1) and `txdIn` = 1 means recessive.
- R4: The driver is forced recessive after it has been dominant for `TIMEOUT_CYCLES`+1 consecutive cycles. A low pulse that gives `TIMEOUT_CYCLES` dominant cycles or fewer passes through with no timeout.
- R5: `timeoutFlag` rises in the same cycle that the forced recessive begins. It stays 1 while the driver remains blocked, and `driveDominant` is 0 for as long as it is 1.
- R6: After a timeout, the driver is re-enabled only after the synchronized `txdIn` has been 1 for more than `RELEASE_CYCLES` consecutive cycles. A high run of exactly `RELEASE_CYCLES` cycles leaves the guard blocked, and the flag clears at the moment of release.
- R7: On every entry into normal mode, the driver stays off until the synchronized `txdIn` has been 1 for more than `RELEASE_CYCLES` consecutive cycles counted from the entry. A `txdIn` that is held low across the entry never drives the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| normalMode | input | 1 | 1 while the transceiver is in normal mode (synchronous) |
| txdIn | input | 1 | Raw transmit line from the microcontroller; 0 requests dominant |
| driveDominant | output | 1 | 1 turns the LIN low-side driver on |
| timeoutFlag | output | 1 | 1 while the driver is blocked after a dominant timeout |

## Verification
A wrong guard state shows up at `driveDominant` within `SYNC_STAGES` cycles of the next transmit edge. A guard that is falsely blocked swallows that edge, and a guard that is falsely open drives the bus at once. Faults in the counters show up only at their limits. An early or late timeout moves the forced recessive edge by whole cycles. An off-by-one in the high qualification decides whether a high run of exactly `RELEASE_CYCLES` cycles unlocks the driver. The bench therefore checks every cycle around these boundaries, and it checks the flag in the same cycles as the driver.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

  typedef enum logic [1:0] {
    GUARD_BLOCKED = 2'd0,
    GUARD_ACTIVE  = 2'd1,
    GUARD_TIMEOUT = 2'd2
  } guardState_e;

  typedef struct packed {
    logic lowCount;
    logic lowClear;
    logic highCount;
    logic highClear;
  } cntStrobes_t;

endpackage

// File: rtl/dtg_satcount.sv
`timescale 1ns/1ps
module dtg_satcount #(
  parameter int LIMIT = 15,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         count,
  output logic [W-1:0] value,
  output logic         atLimit
);

  localparam logic [W-1:0] MAXV = W'(LIMIT);

  // clear has priority over count; the value holds at MAXV
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= '0;
    end else if (clear) begin
      value <= '0;
    end else if (count && (value != MAXV)) begin
      value <= value + 1'b1;
    end
  end

  assign atLimit = (value == MAXV);

endmodule

// File: rtl/dtg_datapath.sv
`timescale 1ns/1ps
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 55000,
  parameter int RELEASE_CYCLES = 11,
  localparam int LOW_W  = $clog2(TIMEOUT_CYCLES + 1),
  localparam int HIGH_W = $clog2(RELEASE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txdIn,
  input  cntStrobes_t       strobes,
  output logic              txdHigh,
  output logic              lowExpired,
  output logic              highQualified,
  output logic [LOW_W-1:0]  lowCount,
  output logic [HIGH_W-1:0] highCount
);

  logic                   rawHigh;
  logic [SYNC_STAGES-1:0] syncQ;

  // only a definite 0 is read as low; unknown or floating reads as high
  assign rawHigh = (txdIn !== 1'b0);

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rawHigh;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawHigh};
      end
    end
  endgenerate

  assign txdHigh = syncQ[SYNC_STAGES-1];

  dtg_satcount #(.LIMIT(TIMEOUT_CYCLES)) u_lowCnt (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobes.lowClear),
    .count   (strobes.lowCount),
    .value   (lowCount),
    .atLimit (lowExpired)
  );

  dtg_satcount #(.LIMIT(RELEASE_CYCLES)) u_highCnt (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobes.highClear),
    .count   (strobes.highCount),
    .value   (highCount),
    .atLimit (highQualified)
  );

endmodule

// File: rtl/dtg_control.sv
`timescale 1ns/1ps
module dtg_control
  import dtg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        normalMode,
  input  logic        txdHigh,
  input  logic        lowExpired,
  input  logic        highQualified,
  output cntStrobes_t strobes,
  output logic        driveDominant,
  output logic        timeoutFlag
);

  guardState_e stateQ, stateD;
  logic        isActive;

  assign isActive = (stateQ == GUARD_ACTIVE);

  always_comb begin
    strobes.lowCount  = isActive && normalMode && !txdHigh;
    strobes.lowClear  = !strobes.lowCount;
    strobes.highCount = !isActive && normalMode && txdHigh;
    strobes.highClear = !strobes.highCount;
  end

  always_comb begin
    stateD = stateQ;
    if (!normalMode) begin
      stateD = GUARD_BLOCKED;
    end else begin
      unique case (stateQ)
        GUARD_ACTIVE:
          if (!txdHigh && lowExpired) stateD = GUARD_TIMEOUT;
        GUARD_BLOCKED, GUARD_TIMEOUT:
          if (txdHigh && highQualified) stateD = GUARD_ACTIVE;
        default:
          stateD = GUARD_BLOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= GUARD_BLOCKED;
    else       stateQ <= stateD;
  end

  assign driveDominant = isActive && normalMode && !txdHigh;
  assign timeoutFlag   = (stateQ == GUARD_TIMEOUT);

endmodule

// File: rtl/dom_timeout_guard.sv
`timescale 1ns/1ps
module dom_timeout_guard
  import dtg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 55000,
  parameter int RELEASE_CYCLES = 11,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic normalMode,
  input  logic txdIn,
  output logic driveDominant,
  output logic timeoutFlag
);

  localparam int LOW_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam int HIGH_W = $clog2(RELEASE_CYCLES + 1);

  cntStrobes_t       strobes;
  logic              txdHigh;
  logic              lowExpired;
  logic              highQualified;
  logic [LOW_W-1:0]  lowCount;
  logic [HIGH_W-1:0] highCount;

  dtg_datapath #(
    .SYNC_STAGES    (SYNC_STAGES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .RELEASE_CYCLES (RELEASE_CYCLES)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .txdIn         (txdIn),
    .strobes       (strobes),
    .txdHigh       (txdHigh),
    .lowExpired    (lowExpired),
    .highQualified (highQualified),
    .lowCount      (lowCount),
    .highCount     (highCount)
  );

  dtg_control u_control (
    .clk           (clk),
    .rstN          (rstN),
    .normalMode    (normalMode),
    .txdHigh       (txdHigh),
    .lowExpired    (lowExpired),
    .highQualified (highQualified),
    .strobes       (strobes),
    .driveDominant (driveDominant),
    .timeoutFlag   (timeoutFlag)
  );

endmodule

// File: rtl/dom_timeout_guard_chk.sv
`timescale 1ns/1ps
module dom_timeout_guard_chk #(
  parameter int TIMEOUT_CYCLES = 55000,
  parameter int RELEASE_CYCLES = 11,
  localparam int LOW_W  = $clog2(TIMEOUT_CYCLES + 1),
  localparam int HIGH_W = $clog2(RELEASE_CYCLES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              normalMode,
  input logic              txdHigh,
  input logic              driveDominant,
  input logic              timeoutFlag,
  input logic [LOW_W-1:0]  lowCount,
  input logic [HIGH_W-1:0] highCount
);

  localparam logic [LOW_W-1:0]  LOW_MAX  = LOW_W'(TIMEOUT_CYCLES);
  localparam logic [HIGH_W-1:0] HIGH_MAX = HIGH_W'(RELEASE_CYCLES);

  assert_leave_normal_R2: assert property (@(posedge clk) disable iff (!rstN)
    !normalMode |=> (!timeoutFlag && !driveDominant));

  assert_low_saturates_R4: assert property (@(posedge clk) disable iff (!rstN)
    lowCount <= LOW_MAX);

  assert_flag_after_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(driveDominant));

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && normalMode && !txdHigh) |=> timeoutFlag);

  assert_flag_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> !driveDominant);

  assert_release_qualified_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutFlag) |->
      (!$past(normalMode) || ($past(txdHigh) && ($past(highCount) == HIGH_MAX))));

  assert_high_saturates_R6: assert property (@(posedge clk) disable iff (!rstN)
    highCount <= HIGH_MAX);

endmodule

bind dom_timeout_guard dom_timeout_guard_chk #(
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
  .RELEASE_CYCLES (RELEASE_CYCLES)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .normalMode    (normalMode),
  .txdHigh       (txdHigh),
  .driveDominant (driveDominant),
  .timeoutFlag   (timeoutFlag),
  .lowCount      (lowCount),
  .highCount     (highCount)
);

// File: tb/tb_dom_timeout_guard.sv
`timescale 1ns/1ps
module tb_dom_timeout_guard;

  localparam int T = 20;
  localparam int R = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic normalMode = 1'b1;
  logic txdIn = 1'b0;
  logic driveDominant;
  logic timeoutFlag;

  int cyc = 0;
  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  typedef struct {
    int    cyc;
    bit    dom;
    bit    flag;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dom_timeout_guard #(
    .TIMEOUT_CYCLES (T),
    .RELEASE_CYCLES (R),
    .SYNC_STAGES    (2)
  ) dut (
    .clk           (clk),
    .rstN          (rstN),
    .normalMode    (normalMode),
    .txdIn         (txdIn),
    .driveDominant (driveDominant),
    .timeoutFlag   (timeoutFlag)
  );

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  task automatic compare(bit expDom, bit expFlag, string tag);
    checkCount++;
    if (driveDominant !== expDom || timeoutFlag !== expFlag) begin
      failCount++;
      $display("FAIL %s cycle %0d: driveDominant=%0b timeoutFlag=%0b, expected %0b %0b",
               tag, cyc, driveDominant, timeoutFlag, expDom, expFlag);
    end
  endtask

  // driver side: push the expected outputs for a span of future cycles
  task automatic expectRange(int first, int last, bit dom, bit flag, string tag);
    for (int k = first; k <= last; k++) begin
      expItem_t item;
      item.cyc = k; item.dom = dom; item.flag = flag; item.tag = tag;
      expQ.push_back(item);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: sample 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
        expItem_t item;
        item = expQ.pop_front();
        if (item.cyc == cyc) begin
          compare(item.dom, item.flag, item.tag);
        end else begin
          checkCount++;
          failCount++;
          $display("FAIL %s cycle %0d: sample missed, expected %0b %0b",
                   item.tag, item.cyc, item.dom, item.flag);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: run hung, actual cycle %0d, expected end before 20000", cyc);
    finishRun();
  end

  initial begin
    int c;
    int c2;
    // R1: reset with aggressive inputs
    waitCycles(3);
    compare(1'b0, 1'b0, "R1");
    normalMode = 1'b0;
    txdIn = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    c = cyc;
    expectRange(c + 1, c + 3, 1'b0, 1'b0, "R1");
    waitCycles(3);
    drain();

    // R2: low TXD outside normal mode never drives
    c = cyc;
    expectRange(c + 1, c + 30, 1'b0, 1'b0, "R2");
    txdIn = 1'b0;
    waitCycles(30);
    drain();

    // R7: entering normal mode with TXD already low
    c = cyc;
    expectRange(c + 1, c + 40, 1'b0, 1'b0, "R7");
    normalMode = 1'b1;
    waitCycles(40);
    drain();

    // R7: high run of exactly R cycles does not qualify
    c = cyc;
    expectRange(c + 1, c + R + 40, 1'b0, 1'b0, "R7");
    txdIn = 1'b1;
    waitCycles(R);
    txdIn = 1'b0;
    waitCycles(40);
    drain();

    // R7 + R3: R+1 high cycles qualify, then TXD is followed
    c = cyc;
    expectRange(c + 1, c + R + 2, 1'b0, 1'b0, "R7");
    expectRange(c + R + 3, c + R + 7, 1'b1, 1'b0, "R3");
    expectRange(c + R + 8, c + R + 11, 1'b0, 1'b0, "R3");
    txdIn = 1'b1;
    waitCycles(R + 1);
    txdIn = 1'b0;
    waitCycles(5);
    txdIn = 1'b1;
    waitCycles(6);
    drain();

    // R4: a low of T cycles passes without a timeout
    c = cyc;
    expectRange(c + 1, c + 1, 1'b0, 1'b0, "R4");
    expectRange(c + 2, c + T + 1, 1'b1, 1'b0, "R4");
    expectRange(c + T + 2, c + T + 12, 1'b0, 1'b0, "R4");
    txdIn = 1'b0;
    waitCycles(T);
    txdIn = 1'b1;
    waitCycles(12);
    drain();
    // R3: still driving after that pulse
    c = cyc;
    expectRange(c + 2, c + 4, 1'b1, 1'b0, "R3");
    expectRange(c + 5, c + 8, 1'b0, 1'b0, "R3");
    txdIn = 1'b0;
    waitCycles(3);
    txdIn = 1'b1;
    waitCycles(6);
    drain();

    // R4 + R5: held low, forced recessive after T+1 dominant cycles
    c = cyc;
    expectRange(c + 1, c + 1, 1'b0, 1'b0, "R4");
    expectRange(c + 2, c + T + 2, 1'b1, 1'b0, "R4");
    expectRange(c + T + 3, c + T + 15, 1'b0, 1'b1, "R5");
    txdIn = 1'b0;
    waitCycles(T + 15);
    drain();

    // R6: R high cycles do not release
    c = cyc;
    expectRange(c + 1, c + R + 25, 1'b0, 1'b1, "R6");
    txdIn = 1'b1;
    waitCycles(R);
    txdIn = 1'b0;
    waitCycles(25);
    drain();

    // R6: R+1 high cycles release, flag clears, driver works again
    c = cyc;
    expectRange(c + 1, c + R + 2, 1'b0, 1'b1, "R6");
    expectRange(c + R + 3, c + R + 5, 1'b1, 1'b0, "R6");
    expectRange(c + R + 6, c + R + 10, 1'b0, 1'b0, "R6");
    txdIn = 1'b1;
    waitCycles(R + 1);
    txdIn = 1'b0;
    waitCycles(3);
    txdIn = 1'b1;
    waitCycles(7);
    drain();

    // R2: leaving normal mode clears the flag
    c = cyc;
    c2 = c + T + 8;
    expectRange(c + 1, c + 1, 1'b0, 1'b0, "R5");
    expectRange(c + 2, c + T + 2, 1'b1, 1'b0, "R4");
    expectRange(c + T + 3, c2, 1'b0, 1'b1, "R5");
    expectRange(c2 + 1, c2 + 12, 1'b0, 1'b0, "R2");
    txdIn = 1'b0;
    waitCycles(T + 8);
    normalMode = 1'b0;
    waitCycles(12);
    drain();

    // R7: re-entry with TXD high, then R2: drop mode while dominant
    txdIn = 1'b1;
    waitCycles(5);
    c = cyc;
    expectRange(c + 1, c + R + 4, 1'b0, 1'b0, "R7");
    expectRange(c + R + 5, c + R + 6, 1'b1, 1'b0, "R7");
    expectRange(c + R + 7, c + R + 12, 1'b0, 1'b0, "R2");
    normalMode = 1'b1;
    waitCycles(R + 3);
    txdIn = 1'b0;
    waitCycles(3);
    normalMode = 1'b0;
    waitCycles(6);
    drain();

    finishRun();
  end

endmodule